// File: doc/BRIEF.md
# NOR Flash Command Decoder

This block is a synthesizable behavioural model of the command state machine found in a parallel NOR flash die. A host issues single-cycle bus writes. Each write carries an address, a data byte and a write strobe. The decoder recognises the multi-cycle unlock grammar, which covers these operations:

- returning to read mode
- the identification (autoselect) read
- program
- chip erase and sector erase
- suspending and resuming a sector erase
- a fast program mode that skips the unlock prefix

Reads return one of three things: array contents, the identification codes, or a polling status word while an embedded operation runs.

The storage is a small internal word array that resets to all ones. Programming can only clear bits. Erase sweeps the targeted words back to all ones, one word per clock. The embedded program time is a scaled-down counter. A `ready` output stays low for as long as an embedded program or erase is running.

The bus runs in word mode or byte mode. In byte mode, addresses count bytes. Bit 0 of the address picks the upper byte of a word when it is 1, and the unlock addresses change accordingly.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the decoder is in read mode, `ready` is 1, and every array word reads FFFFh.
- R2: The unlock prefix is AAh written to 555h and then 55h written to 2AAh in word mode, or AAh to AAAh and then 55h to 555h in byte mode. Only address bits [10:0] are compared in word mode and bits [11:0] in byte mode, so higher bits are ignored.
- R3: The prefix, then A0h at the first unlock address, then a write of address PA and data PD programs word PA with the old value AND PD. `ready` is 0 for exactly PROG_CYC cycles, starting the cycle after the PA/PD write.
- R4: A read while busy returns a status word. Bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during an erase. Bit 6 inverts on each such read. All other bits are 0.
- R5: The prefix followed by 90h at the first unlock address enters identification mode. A read with A0=0 returns 0004h. A read with A0=1 returns 22DAh in word mode or 00DAh in byte mode. A0 is address bit 0 in word mode and bit 1 in byte mode. F0h returns to read mode.
- R6: Chip erase is the prefix, 80h, the prefix again, then 10h at the first unlock address. It sets every word to FFFFh and holds `ready` low for 2^MEM_AW cycles.
- R7: Sector erase is the same sequence ending with 30h at any address in the target sector. The sector is word-address bits [MEM_AW-1:SECT_AW]. Only that sector becomes FFFFh, and `ready` is low for 2^SECT_AW cycles.
- R8: During a sector erase, B0h at any address suspends it: `ready` returns to 1 and reads return array contents. A later 30h at any address resumes the erase, which then completes the words not yet erased.
- R9: F0h written at any address in read mode, or after the unlock prefix, leaves the decoder in read mode with the array unchanged.
- R10: A write that breaks the expected sequence returns the decoder to read mode. A following data write does not change the array.
- R11: The prefix followed by 20h enters fast mode. There, A0h at any address followed by the PA/PD write programs as in R3, and the decoder stays in fast mode. 90h followed by F0h leaves fast mode, after which A0h plus a data write no longer programs.
- R12: In byte mode a program changes only the addressed byte. A read returns that byte in bits [7:0] with zeros above.
- R13: While a program is running, bus writes are ignored. Writes issued during the busy window start no new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects the 8-bit bus with byte addressing |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus address |
| wr_data | input | 16 | Write data; commands use bits [7:0] |
| rd_data | output | 16 | Read result, updated the cycle after `rd_en` |
| ready | output | 1 | 0 while an embedded program or erase runs |

## Verification
A read result appears on `rd_data` one cycle after the clock edge that samples `rd_en`. `ready` falls on the edge that accepts the final command write. It rises again PROG_CYC, 2^SECT_AW or 2^MEM_AW edges later for a program, a sector erase or a chip erase. The bench drives every strobe from a falling edge and releases it at the next falling edge, so each write or read takes exactly one edge. It samples `rd_data` at that second falling edge. It counts the falling edges until `ready` returns and compares that count with the exact duration for the operation.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        ST_READ, ST_U1, ST_U2, ST_PRG_ARM, ST_ER1, ST_ER2, ST_ER3, ST_AUTO,
        ST_PROG, ST_ERASE, ST_SUSP, ST_BYP, ST_BYP_ARM, ST_BYP_X
    } cmd_state_e;

    localparam logic [7:0] OP_KEY1    = 8'hAA;
    localparam logic [7:0] OP_KEY2    = 8'h55;
    localparam logic [7:0] OP_RESET   = 8'hF0;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_PROG    = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_SECTOR  = 8'h30;
    localparam logic [7:0] OP_PAUSE   = 8'hB0;
    localparam logic [7:0] OP_FAST    = 8'h20;

    localparam logic [DATA_W-1:0] ID_MAKER  = 16'h0004;
    localparam logic [DATA_W-1:0] ID_DEVICE = 16'h22DA;
endpackage

// File: rtl/nor_unlock_match.sv
module nor_unlock_match #(
    parameter int ADDR_W = 12
) (
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_first,
    output logic              hit_second
);
    // word mode compares 11 bits, byte mode 12 (extra low address bit)
    always_comb begin
        if (byte_mode) begin
            hit_first  = (addr[11:0] == 12'hAAA);
            hit_second = (addr[11:0] == 12'h555);
        end else begin
            hit_first  = (addr[10:0] == 11'h555);
            hit_second = (addr[10:0] == 11'h2AA);
        end
    end
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
    parameter int MEM_AW = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [MEM_AW-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MEM_AW   = 6,
    parameter int SECT_AW  = 4,
    parameter int PROG_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              ready
);
    localparam int CNT_W = $clog2(PROG_CYC) + 1;

    typedef struct packed {
        cmd_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [MEM_AW-1:0] ptr;
        logic [MEM_AW-1:0] last;
        logic              sect_er;
        logic [MEM_AW-1:0] paddr;
        logic [DATA_W-1:0] pmask;
        logic              pd7;
        logic              byp;
        logic              tog;
        logic [DATA_W-1:0] rd;
    } regs_t;

    regs_t q, n;

    logic              hit1, hit2;
    logic [MEM_AW-1:0] widx;
    logic              lane_hi, a0;
    logic [7:0]        cmd;
    logic              busy;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata, rd_a, rd_b;

    nor_unlock_match #(.ADDR_W(ADDR_W)) u_match (
        .byte_mode (byte_mode),
        .addr      (bus_addr),
        .hit_first (hit1),
        .hit_second(hit2)
    );

    nor_word_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr_a(widx),
        .rdata_a(rd_a),
        .raddr_b(q.paddr),
        .rdata_b(rd_b)
    );

    assign widx    = byte_mode ? bus_addr[MEM_AW:1] : bus_addr[MEM_AW-1:0];
    assign lane_hi = byte_mode & bus_addr[0];
    assign a0      = byte_mode ? bus_addr[1] : bus_addr[0];
    assign cmd     = wr_data[7:0];
    assign busy    = (q.st == ST_PROG) || (q.st == ST_ERASE);

    always_comb begin
        n         = q;
        mem_we    = 1'b0;
        mem_waddr = q.ptr;
        mem_wdata = '1;

        unique case (q.st)
            ST_READ: if (wr_en && cmd == OP_KEY1 && hit1) n.st = ST_U1;
            ST_U1:   if (wr_en) n.st = (cmd == OP_KEY2 && hit2) ? ST_U2 : ST_READ;
            ST_U2: if (wr_en) begin
                n.st = ST_READ;
                if (hit1) begin
                    unique case (cmd)
                        OP_IDENT: n.st = ST_AUTO;
                        OP_PROG:  n.st = ST_PRG_ARM;
                        OP_ERASE: n.st = ST_ER1;
                        OP_FAST:  begin n.st = ST_BYP; n.byp = 1'b1; end
                        default:  n.st = ST_READ;
                    endcase
                end
            end
            ST_PRG_ARM, ST_BYP_ARM: if (wr_en) begin
                n.st    = ST_PROG;
                n.cnt   = CNT_W'(PROG_CYC - 1);
                n.paddr = widx;
                n.pd7   = wr_data[7];
                if (!byte_mode)   n.pmask = wr_data;
                else if (lane_hi) n.pmask = {cmd, 8'hFF};
                else              n.pmask = {8'hFF, cmd};
            end
            ST_ER1: if (wr_en) n.st = (cmd == OP_KEY1 && hit1) ? ST_ER2 : ST_READ;
            ST_ER2: if (wr_en) n.st = (cmd == OP_KEY2 && hit2) ? ST_ER3 : ST_READ;
            ST_ER3: if (wr_en) begin
                n.st = ST_READ;
                if (cmd == OP_CHIP && hit1) begin
                    n.st      = ST_ERASE;
                    n.ptr     = '0;
                    n.last    = '1;
                    n.sect_er = 1'b0;
                end else if (cmd == OP_SECTOR) begin
                    n.st      = ST_ERASE;
                    n.ptr     = {widx[MEM_AW-1:SECT_AW], {SECT_AW{1'b0}}};
                    n.last    = {widx[MEM_AW-1:SECT_AW], {SECT_AW{1'b1}}};
                    n.sect_er = 1'b1;
                end
            end
            ST_AUTO: if (wr_en && cmd == OP_RESET) n.st = ST_READ;
            ST_PROG: begin
                if (q.cnt == '0) begin
                    mem_we    = 1'b1;
                    mem_waddr = q.paddr;
                    mem_wdata = rd_b & q.pmask;
                    n.st      = q.byp ? ST_BYP : ST_READ;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (wr_en && cmd == OP_PAUSE && q.sect_er) begin
                    n.st = ST_SUSP;
                end else begin
                    mem_we = 1'b1;
                    if (q.ptr == q.last) n.st = ST_READ;
                    else                 n.ptr = q.ptr + 1'b1;
                end
            end
            ST_SUSP: if (wr_en && cmd == OP_SECTOR) n.st = ST_ERASE;
            ST_BYP: if (wr_en) begin
                if (cmd == OP_PROG)       n.st = ST_BYP_ARM;
                else if (cmd == OP_IDENT) n.st = ST_BYP_X;
            end
            ST_BYP_X: if (wr_en) begin
                if (cmd == OP_RESET) begin
                    n.st  = ST_READ;
                    n.byp = 1'b0;
                end else begin
                    n.st = ST_BYP;
                end
            end
            default: n.st = ST_READ;
        endcase

        if (rd_en) begin
            if (busy) begin
                n.rd  = {8'h00, (q.st == ST_PROG) ? ~q.pd7 : 1'b0, q.tog, 6'b0};
                n.tog = ~q.tog;
            end else if (q.st == ST_AUTO) begin
                if (!a0)           n.rd = ID_MAKER;
                else if (byte_mode) n.rd = {8'h00, ID_DEVICE[7:0]};
                else               n.rd = ID_DEVICE;
            end else if (byte_mode) begin
                n.rd = lane_hi ? {8'h00, rd_a[15:8]} : {8'h00, rd_a[7:0]};
            end else begin
                n.rd = rd_a;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_READ;
        end else begin
            q <= n;
        end
    end

    assign rd_data = q.rd;
    assign ready   = ~busy;

    a_r3_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PRG_ARM && wr_en) |=> !ready);
    a_r7_sweep_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ERASE) |-> (q.ptr <= q.last));
    a_r8_pause_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SUSP) |=> $stable(q.ptr));
    a_r10_array_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.st inside {ST_PROG, ST_ERASE}) |-> !mem_we);
    a_r11_fast_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BYP_X && wr_en && cmd == OP_RESET) |=> (q.st == ST_READ && !q.byp));
    a_r4_toggle_on_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (q.tog != $past(q.tog)));
endmodule

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;
    localparam int MEM_AW   = 6;
    localparam int SECT_AW  = 4;
    localparam int PROG_CYC = 8;
    localparam int DEPTH    = 1 << MEM_AW;
    localparam int SWORDS   = 1 << SECT_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ready;

    int total = 0;
    int bad = 0;
    logic [15:0] model [DEPTH];

    always #5 clk = ~clk;

    nor_cmd_engine #(.ADDR_W(12), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .PROG_CYC(PROG_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en), .rd_en(rd_en),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data), .ready(ready)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic prefix(input logic [11:0] hi);
        if (byte_mode) begin wr(hi | 12'hAAA, 16'h00AA); wr(hi | 12'h555, 16'h0055); end
        else           begin wr(hi | 12'h555, 16'h00AA); wr(hi | 12'h2AA, 16'h0055); end
    endtask

    task automatic check_word(input string tag, input int w);
        logic [15:0] v;
        rd(12'(w), v);
        check(tag, v, model[w]);
    endtask

    task automatic program_word(input string tag, input logic [11:0] hi, input int w, input logic [15:0] d);
        int n;
        prefix(hi);
        wr(hi | 12'h555, 16'h00A0);
        wr(12'(w), d);
        check({tag, " busy after write"}, 16'(ready), 16'h0);
        wait_idle(n);
        check({tag, " busy length"}, 16'(n), 16'(PROG_CYC));
        model[w] = model[w] & d;
        check_word(tag, w);
    endtask

    task automatic t_reset();
        check("R1 ready", 16'(ready), 16'h1);
        check_word("R1 word0", 0);
        check_word("R1 word last", DEPTH - 1);
    endtask

    task automatic t_program();
        program_word("R3 first", 12'h000, 3, 16'h1234);
        program_word("R3 and", 12'h000, 3, 16'hFF00);
        program_word("R2 high bit ignored", 12'h800, 7, 16'h00F0);
    endtask

    task automatic t_status();
        logic [15:0] s1, s2;
        int n;
        prefix(12'h000);
        wr(12'h555, 16'h00A0);
        wr(12'd9, 16'h0F0F);
        rd(12'd9, s1);
        rd(12'd9, s2);
        check("R4 bit7 complement", {15'h0, s1[7]}, 16'h1);
        check("R4 other bits", s1 & 16'hFF3F, 16'h0);
        check("R4 toggle", {15'h0, s1[6] ^ s2[6]}, 16'h1);
        wait_idle(n);
        model[9] = 16'h0F0F;
        check_word("R4 result", 9);
    endtask

    task automatic t_busy_ignore();
        int n;
        prefix(12'h000);
        wr(12'h555, 16'h00A0);
        wr(12'd10, 16'hAAAA);
        prefix(12'h000);
        wr(12'h555, 16'h00A0);
        wr(12'd11, 16'h0000);
        wait_idle(n);
        wr(12'd11, 16'h0000);
        model[10] = 16'hAAAA;
        check_word("R13 running program done", 10);
        check_word("R13 busy writes ignored", 11);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        prefix(12'h000);
        wr(12'h555, 16'h0090);
        rd(12'h000, v); check("R5 maker word", v, 16'h0004);
        rd(12'h001, v); check("R5 device word", v, 16'h22DA);
        wr(12'h000, 16'h00F0);
        check_word("R5 back to read", 3);
    endtask

    task automatic t_resets_and_breaks();
        wr(12'h123, 16'h00F0);
        wr(12'd3, 16'h0000);
        check_word("R9 single reset", 3);
        prefix(12'h000);
        wr(12'h555, 16'h00F0);
        wr(12'd3, 16'h0000);
        check_word("R9 prefixed reset", 3);
        wr(12'h555, 16'h00AA);
        wr(12'h123, 16'h0055);
        wr(12'h555, 16'h00A0);
        wr(12'd3, 16'h0000);
        check_word("R10 bad second address", 3);
        prefix(12'h000);
        wr(12'h555, 16'h0077);
        wr(12'd3, 16'h0000);
        check_word("R10 unknown command", 3);
    endtask

    task automatic t_sector_suspend();
        int n;
        logic [15:0] v;
        program_word("R7 setup", 12'h000, 20, 16'h0000);
        program_word("R7 setup", 12'h000, 31, 16'h0000);
        prefix(12'h000); wr(12'h555, 16'h0080);
        prefix(12'h000); wr(12'd17, 16'h0030);
        wr(12'h3C7, 16'h00B0);
        check("R8 ready when paused", 16'(ready), 16'h1);
        rd(12'd20, v);
        check("R8 read while paused", v, 16'h0000);
        wr(12'h001, 16'h0030);
        wait_idle(n);
        check("R8 remaining sweep", 16'(n), 16'(SWORDS));
        for (int i = SWORDS; i < 2 * SWORDS; i++) model[i] = 16'hFFFF;
        check_word("R7 sector word 20", 20);
        check_word("R7 sector word 31", 31);
        check_word("R7 other sector kept", 3);
        check_word("R7 other sector kept", 10);
    endtask

    task automatic t_fast();
        int n;
        prefix(12'h000);
        wr(12'h555, 16'h0020);
        wr(12'h123, 16'h00A0);
        wr(12'd40, 16'h0FF0);
        wait_idle(n);
        check("R11 fast busy length", 16'(n), 16'(PROG_CYC));
        wr(12'h000, 16'h00A0);
        wr(12'd41, 16'h1111);
        wait_idle(n);
        wr(12'h000, 16'h0090);
        wr(12'h000, 16'h00F0);
        wr(12'h555, 16'h00A0);
        wr(12'd42, 16'h0000);
        model[40] = 16'h0FF0;
        model[41] = 16'h1111;
        check_word("R11 first", 40);
        check_word("R11 second", 41);
        check_word("R11 after exit", 42);
    endtask

    task automatic t_byte();
        int n;
        logic [15:0] v;
        byte_mode = 1'b1;
        prefix(12'h000);
        wr(12'hAAA, 16'h00A0);
        wr(12'd11, 16'h003C);
        wait_idle(n);
        check("R12 byte program length", 16'(n), 16'(PROG_CYC));
        rd(12'd10, v); check("R12 low byte", v, 16'h00FF);
        rd(12'd11, v); check("R12 high byte", v, 16'h003C);
        prefix(12'h000);
        wr(12'hAAA, 16'h0090);
        rd(12'h002, v); check("R5 device byte", v, 16'h00DA);
        rd(12'h000, v); check("R5 maker byte", v, 16'h0004);
        wr(12'h000, 16'h00F0);
        byte_mode = 1'b0;
        model[5] = 16'h3CFF;
        check_word("R12 word view", 5);
    endtask

    task automatic t_chip();
        int n;
        logic [15:0] v;
        prefix(12'h000); wr(12'h555, 16'h0080);
        prefix(12'h000); wr(12'h555, 16'h0010);
        rd(12'd0, v);
        check("R4 erase status", v & 16'hFFBF, 16'h0);
        wait_idle(n);
        check("R6 chip erase length", 16'(n), 16'(DEPTH - 1));
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        check_word("R6 word 3", 3);
        check_word("R6 word 5", 5);
        check_word("R6 word 40", 40);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_status();
        t_busy_ignore();
        t_ident();
        t_resets_and_breaks();
        t_sector_suspend();
        t_fast();
        t_byte();
        t_chip();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule